// File: doc/BRIEF.md
# Unlock Command Sequence Decoder

This block sits beside a nonvolatile memory controller and watches every byte write that reaches it. Each write carries an address and a data byte. Protected operations are reached only through fixed multi-write unlock codes. The decoder follows these codes with a small sequence machine, and all codes share the same two-write opening. After that opening, the third write picks one of four paths: a one-shot program enable, entry to identification mode, exit from identification mode, or the longer path that arms a boot-region lockout.

The program enable is a single-cycle pulse sent to the program sequencer, which owns the sector buffer and the timer. The machine goes back to idle at once, so every new program operation must repeat the full code. Each of the two boot regions has a sticky lock flag that only reset clears, and both flags go out to the sequencer. While identification mode is active, the read port returns the vendor code, the device code and the two lock status bytes at their fixed locations. Outside identification mode the read port reports no hit.

Top module: `unlock_seq_dec`

## Requirements
- R1: The three writes AA@5555, 55@2AAA, A0@5555 (hex, in that order) raise `prog_go` for exactly one cycle, in the cycle after the third write is sampled. A lone A0@5555 written afterwards gives no pulse, so every program operation needs the full code.
- R2: Command writes compare only address bits 14..0. Higher address bits are ignored, and a difference in any of bits 14..0 breaks the match.
- R3: The third write 90@5555 sets `id_mode` and the third write F0@5555 clears it. Either change is visible the cycle after that write.
- R4: With `id_mode` high, a read of address 0 returns 1F and a read of address 1 returns C4, each with `rd_hit` high. When `id_mode` is low, or the address is not an identification location, `rd_hit` is 0 and `rd_data` is 00.
- R5: With `id_mode` high, address 2 returns the lower-region status and the address with bits 18..4 all ones and low nibble 2 (7FFF2) returns the upper-region status. The status byte is FE when the region is open and FF when it is locked.
- R6: The six writes AA@5555, 55@2AAA, 80@5555, AA@5555, 55@2AAA, 40@5555 arm the lockout. A following 00 written to full address 00000 pulses `lock_lo_req` and sets `lock_lo`. A following FF written to the all-ones full address (7FFFF) pulses `lock_hi_req` and sets `lock_hi`. This final write compares all 19 address bits.
- R7: `lock_lo` and `lock_hi` stay set until reset.
- R8: A write that is not the expected next byte returns the machine to idle. If that write is itself AA@5555, it starts a new sequence.
- R9: Cycles with `wr_en` low change no state and raise no pulse, whatever the address and data inputs carry.
- R10: After reset, `prog_go`, `lock_lo_req`, `lock_hi_req`, `lock_lo`, `lock_hi` and `id_mode` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | 19 | Write address |
| wr_data | input | 8 | Write data byte |
| rd_addr | input | 19 | Read address for identification locations |
| rd_data | output | 8 | Identification read data, 00 when no hit |
| rd_hit | output | 1 | Read address is an identification location and the mode is active |
| id_mode | output | 1 | Identification mode active |
| prog_go | output | 1 | One-cycle program enable pulse |
| lock_lo_req | output | 1 | One-cycle request to lock the lower boot region |
| lock_hi_req | output | 1 | One-cycle request to lock the upper boot region |
| lock_lo | output | 1 | Sticky lower boot region lock |
| lock_hi | output | 1 | Sticky upper boot region lock |

## Verification
The assertions check on every cycle that pulses last a single cycle and never overlap, that lock flags never drop, that a lock request is followed by its flag, that idle bus cycles leave the mode and the pulses alone, and that a read hit happens only in identification mode. Whether a given sequence of writes actually reaches its target action, depends on the correct addresses and bits, and restarts properly after a broken prefix, can be shown only by the bench. The bench does this with its queue-based model and with directed write streams, including near-miss addresses and interrupted codes.

// File: rtl/unlock_seq_pkg.sv
`timescale 1ns/1ps
package unlock_seq_pkg;

    localparam int CMD_AW = 15;   // command address bits that take part in matching
    localparam int NPAT   = 7;    // number of distinct command address/data pairs

    // indices into the command match vector
    localparam int P_AA = 0;
    localparam int P_55 = 1;
    localparam int P_A0 = 2;
    localparam int P_90 = 3;
    localparam int P_F0 = 4;
    localparam int P_80 = 5;
    localparam int P_40 = 6;

    localparam logic [7:0] MFG_CODE  = 8'h1F;
    localparam logic [7:0] DEV_CODE  = 8'hC4;
    localparam logic [7:0] LK_OPEN   = 8'hFE;
    localparam logic [7:0] LK_SHUT   = 8'hFF;

    typedef enum logic [2:0] {
        ST_IDLE,   // nothing accepted
        ST_K1,     // first opening byte seen
        ST_K2,     // opening pair seen, third byte selects the path
        ST_X1,     // lockout path entered
        ST_X2,     // lockout path, second opening byte
        ST_X3,     // lockout path, second opening pair
        ST_ARM     // lockout armed, awaiting region select
    } seq_st_e;

    typedef struct packed {
        seq_st_e st;
        logic    id;
        logic    lk_lo;
        logic    lk_hi;
        logic    prog;
        logic    lo_req;
        logic    hi_req;
    } seq_regs_t;

    function automatic logic [CMD_AW-1:0] pat_addr(input int idx);
        return (idx == P_55) ? CMD_AW'(15'h2AAA) : CMD_AW'(15'h5555);
    endfunction

    function automatic logic [7:0] pat_data(input int idx);
        case (idx)
            P_AA:    return 8'hAA;
            P_55:    return 8'h55;
            P_A0:    return 8'hA0;
            P_90:    return 8'h90;
            P_F0:    return 8'hF0;
            P_80:    return 8'h80;
            default: return 8'h40;
        endcase
    endfunction

endpackage

// File: rtl/cmd_match.sv
`timescale 1ns/1ps
module cmd_match
    import unlock_seq_pkg::*;
#(
    parameter int AW = 19
) (
    input  logic [AW-1:0]   addr,
    input  logic [7:0]      data,
    output logic [NPAT-1:0] hit,
    output logic            lo_fin,
    output logic            hi_fin
);
    // one comparator per command pair, over the low command bits only
    for (genvar g = 0; g < NPAT; g++) begin : g_pat
        assign hit[g] = (addr[CMD_AW-1:0] == pat_addr(g)) && (data == pat_data(g));
    end

    // region select compares the whole address
    assign lo_fin = (addr == '0) && (data == 8'h00);
    assign hi_fin = (&addr)      && (data == 8'hFF);

endmodule

// File: rtl/seq_fsm.sv
`timescale 1ns/1ps
module seq_fsm
    import unlock_seq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [NPAT-1:0] hit,
    input  logic            lo_fin,
    input  logic            hi_fin,
    output logic            id_mode,
    output logic            prog_go,
    output logic            lo_req,
    output logic            hi_req,
    output logic            lock_lo,
    output logic            lock_hi
);
    seq_regs_t r_d, r_q;
    seq_st_e   restart;

    always_comb begin
        r_d        = r_q;
        r_d.prog   = 1'b0;
        r_d.lo_req = 1'b0;
        r_d.hi_req = 1'b0;
        restart    = hit[P_AA] ? ST_K1 : ST_IDLE;
        if (wr_en) begin
            case (r_q.st)
                ST_IDLE: r_d.st = restart;
                ST_K1:   r_d.st = hit[P_55] ? ST_K2 : restart;
                ST_K2: begin
                    if (hit[P_A0]) begin
                        r_d.prog = 1'b1;
                        r_d.st   = ST_IDLE;
                    end else if (hit[P_90]) begin
                        r_d.id = 1'b1;
                        r_d.st = ST_IDLE;
                    end else if (hit[P_F0]) begin
                        r_d.id = 1'b0;
                        r_d.st = ST_IDLE;
                    end else if (hit[P_80]) begin
                        r_d.st = ST_X1;
                    end else begin
                        r_d.st = restart;
                    end
                end
                ST_X1:   r_d.st = hit[P_AA] ? ST_X2 : restart;
                ST_X2:   r_d.st = hit[P_55] ? ST_X3 : restart;
                ST_X3:   r_d.st = hit[P_40] ? ST_ARM : restart;
                ST_ARM: begin
                    if (lo_fin) begin
                        r_d.lk_lo  = 1'b1;
                        r_d.lo_req = 1'b1;
                        r_d.st     = ST_IDLE;
                    end else if (hi_fin) begin
                        r_d.lk_hi  = 1'b1;
                        r_d.hi_req = 1'b1;
                        r_d.st     = ST_IDLE;
                    end else begin
                        r_d.st = restart;
                    end
                end
                default: r_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, default: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign id_mode = r_q.id;
    assign prog_go = r_q.prog;
    assign lo_req  = r_q.lo_req;
    assign hi_req  = r_q.hi_req;
    assign lock_lo = r_q.lk_lo;
    assign lock_hi = r_q.lk_hi;

endmodule

// File: rtl/id_read_mux.sv
`timescale 1ns/1ps
module id_read_mux
    import unlock_seq_pkg::*;
#(
    parameter int AW = 19
) (
    input  logic          id_mode,
    input  logic          lock_lo,
    input  logic          lock_hi,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data,
    output logic          rd_hit
);
    localparam logic [AW-1:0] A_MFG   = AW'(0);
    localparam logic [AW-1:0] A_DEV   = AW'(1);
    localparam logic [AW-1:0] A_LK_LO = AW'(2);
    localparam logic [AW-1:0] A_LK_HI = {{(AW-4){1'b1}}, 4'h2};

    always_comb begin
        rd_data = 8'h00;
        rd_hit  = 1'b0;
        if (id_mode) begin
            rd_hit = 1'b1;
            if (rd_addr == A_MFG)        rd_data = MFG_CODE;
            else if (rd_addr == A_DEV)   rd_data = DEV_CODE;
            else if (rd_addr == A_LK_LO) rd_data = lock_lo ? LK_SHUT : LK_OPEN;
            else if (rd_addr == A_LK_HI) rd_data = lock_hi ? LK_SHUT : LK_OPEN;
            else                         rd_hit  = 1'b0;
        end
    end

endmodule

// File: rtl/unlock_seq_dec.sv
`timescale 1ns/1ps
module unlock_seq_dec
    import unlock_seq_pkg::*;
#(
    parameter int AW = 19
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data,
    output logic          rd_hit,
    output logic          id_mode,
    output logic          prog_go,
    output logic          lock_lo_req,
    output logic          lock_hi_req,
    output logic          lock_lo,
    output logic          lock_hi
);
    logic [NPAT-1:0] hit;
    logic            lo_fin, hi_fin;

    cmd_match #(.AW(AW)) u_match (
        .addr   (wr_addr),
        .data   (wr_data),
        .hit    (hit),
        .lo_fin (lo_fin),
        .hi_fin (hi_fin)
    );

    seq_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .hit     (hit),
        .lo_fin  (lo_fin),
        .hi_fin  (hi_fin),
        .id_mode (id_mode),
        .prog_go (prog_go),
        .lo_req  (lock_lo_req),
        .hi_req  (lock_hi_req),
        .lock_lo (lock_lo),
        .lock_hi (lock_hi)
    );

    id_read_mux #(.AW(AW)) u_rd (
        .id_mode (id_mode),
        .lock_lo (lock_lo),
        .lock_hi (lock_hi),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .rd_hit  (rd_hit)
    );

endmodule

// File: rtl/unlock_seq_chk.sv
`timescale 1ns/1ps
module unlock_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic wr_en,
    input logic rd_hit,
    input logic id_mode,
    input logic prog_go,
    input logic lock_lo_req,
    input logic lock_hi_req,
    input logic lock_lo,
    input logic lock_hi
);
    // R1
    prog_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_go |=> !prog_go);

    // R6
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({prog_go, lock_lo_req, lock_hi_req}));

    // R6
    lo_req_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_lo_req |-> lock_lo);

    // R6
    hi_req_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_hi_req |-> lock_hi);

    // R7
    lo_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_lo |=> lock_lo);

    // R7
    hi_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_hi |=> lock_hi);

    // R9
    idle_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> !(prog_go || lock_lo_req || lock_hi_req));

    // R9
    idle_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(id_mode));

    // R4
    hit_needs_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hit |-> id_mode);

endmodule

bind unlock_seq_dec unlock_seq_chk u_seq_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .rd_hit      (rd_hit),
    .id_mode     (id_mode),
    .prog_go     (prog_go),
    .lock_lo_req (lock_lo_req),
    .lock_hi_req (lock_hi_req),
    .lock_lo     (lock_lo),
    .lock_hi     (lock_hi)
);

// File: tb/unlock_seq_dec_bench.sv
`timescale 1ns/1ps
module unlock_seq_dec_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [18:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [18:0] rd_addr = '0;
    logic [7:0]  rd_data;
    logic        rd_hit, id_mode, prog_go, lock_lo_req, lock_hi_req, lock_lo, lock_hi;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    unlock_seq_dec u_unlock_seq_dec (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .rd_hit(rd_hit), .id_mode(id_mode),
        .prog_go(prog_go), .lock_lo_req(lock_lo_req), .lock_hi_req(lock_hi_req),
        .lock_lo(lock_lo), .lock_hi(lock_hi)
    );

    // ---------------- reference model ----------------
    logic [26:0] hist[$];
    bit m_id, m_lo, m_hi, m_prog, m_loreq, m_hireq;

    function automatic int plen(int p);
        return (p < 3) ? 3 : 7;
    endfunction

    // pattern 0 program, 1 id enter, 2 id exit, 3 lower lock, 4 upper lock
    function automatic bit elem_ok(int p, int k, logic [18:0] a, logic [7:0] d);
        logic [14:0] la;
        la = a[14:0];
        case (k)
            0, 3: return la == 15'h5555 && d == 8'hAA;
            1, 4: return la == 15'h2AAA && d == 8'h55;
            2: begin
                if (la != 15'h5555) return 1'b0;
                case (p)
                    0: return d == 8'hA0;
                    1: return d == 8'h90;
                    2: return d == 8'hF0;
                    default: return d == 8'h80;
                endcase
            end
            5: return la == 15'h5555 && d == 8'h40;
            default: return (p == 3) ? (a == 19'h0 && d == 8'h00)
                                     : (a == 19'h7FFFF && d == 8'hFF);
        endcase
    endfunction

    task automatic model_write(logic [18:0] a, logic [7:0] d);
        int  full;
        bit  pre;
        full = -1;
        pre  = 1'b0;
        hist.push_back({a, d});
        for (int p = 0; p < 5; p++) begin
            if (hist.size() <= plen(p)) begin
                bit ok;
                ok = 1'b1;
                for (int k = 0; k < hist.size(); k++)
                    ok &= elem_ok(p, k, hist[k][26:8], hist[k][7:0]);
                if (ok) begin
                    pre = 1'b1;
                    if (hist.size() == plen(p)) full = p;
                end
            end
        end
        if (full >= 0) begin
            case (full)
                0: m_prog = 1'b1;
                1: m_id   = 1'b1;
                2: m_id   = 1'b0;
                3: begin m_lo = 1'b1; m_loreq = 1'b1; end
                default: begin m_hi = 1'b1; m_hireq = 1'b1; end
            endcase
            hist.delete();
        end else if (!pre) begin
            hist.delete();
            if (elem_ok(0, 0, a, d)) hist.push_back({a, d});
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            hist.delete();
            m_id = 0; m_lo = 0; m_hi = 0; m_prog = 0; m_loreq = 0; m_hireq = 0;
        end else begin
            m_prog = 0; m_loreq = 0; m_hireq = 0;
            if (wr_en) model_write(wr_addr, wr_data);
        end
    end

    function automatic logic [8:0] exp_rd(logic [18:0] a);
        if (!m_id)            return 9'h000;
        if (a == 19'h0)       return {1'b1, 8'h1F};
        if (a == 19'h1)       return {1'b1, 8'hC4};
        if (a == 19'h2)       return {1'b1, m_lo ? 8'hFF : 8'hFE};
        if (a == 19'h7FFF2)   return {1'b1, m_hi ? 8'hFF : 8'hFE};
        return 9'h000;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the model, away from the edge
    always @(negedge clk) begin
        #1;
        if (rst_n && !done) begin
            chk("R1 model prog_go", 32'(prog_go), 32'(m_prog));
            chk("R3 model id_mode", 32'(id_mode), 32'(m_id));
            chk("R6 model lock_lo_req", 32'(lock_lo_req), 32'(m_loreq));
            chk("R6 model lock_hi_req", 32'(lock_hi_req), 32'(m_hireq));
            chk("R7 model lock_lo", 32'(lock_lo), 32'(m_lo));
            chk("R7 model lock_hi", 32'(lock_hi), 32'(m_hi));
            chk("R4 model read", 32'({rd_hit, rd_data}), 32'(exp_rd(rd_addr)));
        end
    end

    // ---------------- stimulus ----------------
    task automatic wr(logic [18:0] a, logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        #2;
    endtask

    task automatic rd(logic [18:0] a, logic h, logic [7:0] d, string tag);
        @(negedge clk);
        rd_addr = a;
        #2;
        chk(tag, 32'({rd_hit, rd_data}), 32'({h, d}));
    endtask

    task automatic lock_prefix();
        wr(19'h05555, 8'hAA); wr(19'h02AAA, 8'h55); wr(19'h05555, 8'h80);
        wr(19'h05555, 8'hAA); wr(19'h02AAA, 8'h55); wr(19'h05555, 8'h40);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #(5.0 * 150000);
        fails++;
        $display("FAIL watchdog expired act=running exp=finished");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        // R10 reset state
        chk("R10 prog_go", 32'(prog_go), 0);
        chk("R10 id_mode", 32'(id_mode), 0);
        chk("R10 lock_lo", 32'(lock_lo), 0);
        chk("R10 lock_hi", 32'(lock_hi), 0);
        chk("R10 lock reqs", 32'({lock_lo_req, lock_hi_req}), 0);
        rst_n = 1'b1;

        // R1 program code and one-cycle pulse
        wr(19'h05555, 8'hAA); wr(19'h02AAA, 8'h55); wr(19'h05555, 8'hA0);
        chk("R1 pulse high", 32'(prog_go), 1);
        @(negedge clk); #2;
        chk("R1 pulse gone", 32'(prog_go), 0);
        wr(19'h05555, 8'hA0);
        chk("R1 lone A0 no pulse", 32'(prog_go), 0);

        // R2 upper address bits ignored, low bits matter
        wr(19'h7D555, 8'hAA); wr(19'h4AAAA, 8'h55); wr(19'h35555, 8'hA0);
        chk("R2 high bits ignored", 32'(prog_go), 1);
        wr(19'h05555, 8'hAA); wr(19'h02AAB, 8'h55); wr(19'h05555, 8'hA0);
        chk("R2 low bit differs", 32'(prog_go), 0);

        // R9 bus activity without strobe
        @(negedge clk);
        wr_addr = 19'h05555; wr_data = 8'hAA; @(negedge clk);
        wr_addr = 19'h02AAA; wr_data = 8'h55; @(negedge clk);
        wr_addr = 19'h05555; wr_data = 8'h90; @(negedge clk);
        #2;
        chk("R9 no strobe id", 32'(id_mode), 0);
        wr(19'h05555, 8'hA0);
        chk("R9 no strobe prog", 32'(prog_go), 0);

        // R3 identification entry; R4 and R5 reads
        rd(19'h0, 1'b0, 8'h00, "R4 read outside id");
        wr(19'h05555, 8'hAA); wr(19'h02AAA, 8'h55); wr(19'h05555, 8'h90);
        chk("R3 id entered", 32'(id_mode), 1);
        rd(19'h0, 1'b1, 8'h1F, "R4 vendor code");
        rd(19'h1, 1'b1, 8'hC4, "R4 device code");
        rd(19'h3, 1'b0, 8'h00, "R4 non-id address");
        rd(19'h2, 1'b1, 8'hFE, "R5 lower open");
        rd(19'h7FFF2, 1'b1, 8'hFE, "R5 upper open");

        // R6 lower lock
        lock_prefix();
        wr(19'h00000, 8'h00);
        chk("R6 lower req", 32'(lock_lo_req), 1);
        chk("R6 lower flag", 32'(lock_lo), 1);
        rd(19'h2, 1'b1, 8'hFF, "R5 lower locked");
        rd(19'h7FFF2, 1'b1, 8'hFE, "R5 upper still open");

        // R6 upper select needs full address
        lock_prefix();
        wr(19'h07FFF, 8'hFF);
        chk("R6 partial address no lock", 32'(lock_hi), 0);
        lock_prefix();
        wr(19'h7FFFF, 8'hFF);
        chk("R6 upper req", 32'(lock_hi_req), 1);
        chk("R6 upper flag", 32'(lock_hi), 1);
        rd(19'h7FFF2, 1'b1, 8'hFF, "R5 upper locked");

        // R8 restarts
        wr(19'h05555, 8'hAA); wr(19'h02AAA, 8'h55);
        wr(19'h05555, 8'hAA); wr(19'h02AAA, 8'h55); wr(19'h05555, 8'hA0);
        chk("R8 restart after broken third", 32'(prog_go), 1);
        wr(19'h05555, 8'hAA); wr(19'h05555, 8'hAA); wr(19'h02AAA, 8'h55); wr(19'h05555, 8'hA0);
        chk("R8 repeated opener", 32'(prog_go), 1);
        wr(19'h05555, 8'hAA); wr(19'h03333, 8'h12); wr(19'h02AAA, 8'h55); wr(19'h05555, 8'hA0);
        chk("R8 stray write to idle", 32'(prog_go), 0);

        // R3 exit
        wr(19'h05555, 8'hAA); wr(19'h02AAA, 8'h55); wr(19'h05555, 8'hF0);
        chk("R3 id left", 32'(id_mode), 0);
        rd(19'h1, 1'b0, 8'h00, "R4 read after exit");

        // R7 sticky through more traffic, cleared by reset
        wr(19'h05555, 8'hAA); wr(19'h02AAA, 8'h55); wr(19'h05555, 8'hA0);
        chk("R7 lower held", 32'(lock_lo), 1);
        chk("R7 upper held", 32'(lock_hi), 1);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); #2;
        chk("R7 reset clears lower", 32'(lock_lo), 0);
        chk("R7 reset clears upper", 32'(lock_hi), 0);
        chk("R10 id after reset", 32'(id_mode), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule